// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading up to two descriptors from a translation table in memory. A request carries the virtual address. The block combines it with the table base input to form the address of the first-level entry. It issues one word read and decodes the two-bit type code of the returned entry.

A section entry finishes the walk at once. A coarse or fine entry points to a second-level table, and a second word read fetches a large, small or tiny page entry. The result holds the physical address together with the access-permission bits, the domain, the cacheable and bufferable bits, and a page-kind code. A fault code at either level ends the walk with a fault flag and the level that faulted.

The block serves a translation lookaside buffer refill path or a similar client. That client holds the table base steady and waits for the one-cycle completion strobe. Memory reads use a level request: the block holds the read strobe and address until the memory returns a one-cycle data-valid pulse.

Top module: `ptw_walker`

## Requirements
- R1: The first read goes to address {base[31:14], va[31:20], 2'b00}, and base bits 13:0 are ignored. The read strobe and address stay stable until data-valid is seen.
- R2: First-level type 00 is a fault. The walk ends with fault=1, fault level 0, no second read, and pa, ap, C, B and kind all zero. The domain output carries bits 8:5 of the first-level entry.
- R3: First-level type 10 is a section. The physical address is {d1[31:20], va[19:0]}, ap is d1[11:10], domain is d1[8:5], C is d1[3] and B is d1[2], and kind is 0.
- R4: First-level type 01 (coarse) causes a second read at {d1[31:10], va[19:12], 2'b00}.
- R5: First-level type 11 (fine) causes a second read at {d1[31:12], va[19:10], 2'b00}.
- R6: Second-level type 00 is a fault. The walk ends with fault=1 and fault level 1, pa, ap, C, B and kind are zero, and the domain comes from the first-level entry.
- R7: Second-level type 01 is a large page. The physical address is {d2[31:16], va[15:0]}. The ap is the two-bit field at d2 bits 4+2k and 5+2k, where k=va[15:14]. Kind is 1, and C and B come from d2[3] and d2[2].
- R8: Second-level type 10 is a small page. The physical address is {d2[31:12], va[11:0]}. The ap is taken the same way with k=va[11:10]. Kind is 2, and C and B are as in R7.
- R9: Second-level type 11 is a tiny page. The physical address is {d2[31:10], va[9:0]}, ap is d2[5:4], kind is 3, and C and B are as in R7.
- R10: The done output pulses for exactly one cycle per request, in the cycle after the last read's data-valid. Ready is low during a walk, and a request presented while busy is ignored.
- R11: After reset, done and the read strobe are low and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ttb_i | input | 32 | Table base; bits 31:14 used |
| req_valid_i | input | 1 | Lookup request, taken when ready is high |
| req_va_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Idle and able to take a request |
| mem_rd_o | output | 1 | Descriptor read strobe |
| mem_addr_o | output | 32 | Descriptor word address |
| mem_rvalid_i | input | 1 | Read data valid pulse |
| mem_rdata_i | input | 32 | Descriptor word |
| done_o | output | 1 | One-cycle completion strobe |
| fault_o | output | 1 | Walk ended in a fault |
| fault_level_o | output | 1 | 0 first level, 1 second level |
| pa_o | output | 32 | Physical address |
| ap_o | output | 2 | Access permission |
| domain_o | output | 4 | Domain from first-level entry |
| cacheable_o | output | 1 | Cacheable bit |
| bufferable_o | output | 1 | Bufferable bit |
| kind_o | output | 2 | 0 section, 1 large, 2 small, 3 tiny |

## Verification
Assertions check the protocol on every cycle:
- the read address stays stable while a read is pending;
- done lasts one cycle and always follows a data-valid;
- no read is issued while idle;
- a fault result always carries zeroed fields;
- a second-level read is entered only from a table entry.

Only the bench's sweeps can show that each address and field is decoded correctly. They cover every type code at both levels, each of the four subpage selections, base values with stray low bits, varying memory latency, and requests injected during a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int AW    = 32;
  localparam int DOM_W = 4;
  localparam int AP_W  = 2;
  localparam int NSUB  = 4;

  typedef enum logic [1:0] {
    KIND_SECTION = 2'd0,
    KIND_LARGE   = 2'd1,
    KIND_SMALL   = 2'd2,
    KIND_TINY    = 2'd3
  } pg_kind_e;

  typedef struct packed {
    logic [AW-1:0]   pa;
    logic [AP_W-1:0] ap;
    logic            c;
    logic            b;
    pg_kind_e        kind;
    logic            fault;
  } xlat_res_t;

  function automatic logic [AW-1:0] l1_desc_addr(input logic [AW-1:0] ttb,
                                                 input logic [AW-1:0] va);
    return {ttb[31:14], va[31:20], 2'b00};
  endfunction

  function automatic logic [AW-1:0] l2_desc_addr(input logic [AW-1:0] d1,
                                                 input logic [AW-1:0] va,
                                                 input logic fine);
    if (fine) return {d1[31:12], va[19:10], 2'b00};
    return {d1[31:10], va[19:12], 2'b00};
  endfunction

  function automatic xlat_res_t fault_res();
    xlat_res_t r;
    r = '0;
    r.fault = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode import ptw_pkg::*; (
  input  logic [AW-1:0]    desc_i,
  input  logic [AW-1:0]    va_i,
  output logic             fault_o,
  output logic             section_o,
  output logic [DOM_W-1:0] domain_o,
  output logic [AW-1:0]    next_addr_o,
  output xlat_res_t        sect_res_o
);
  logic fine;
  logic unused_bits;
  assign unused_bits = ^{desc_i[9], desc_i[4], va_i[31:20]};

  always_comb begin
    fault_o   = 1'b0;
    section_o = 1'b0;
    fine      = 1'b0;
    unique case (desc_i[1:0])
      2'b00: fault_o   = 1'b1;
      2'b10: section_o = 1'b1;
      2'b11: fine      = 1'b1;
      default: ;
    endcase
  end

  assign domain_o    = desc_i[8:5];
  assign next_addr_o = l2_desc_addr(desc_i, va_i, fine);

  always_comb begin
    sect_res_o       = '0;
    sect_res_o.pa    = {desc_i[31:20], va_i[19:0]};
    sect_res_o.ap    = desc_i[11:10];
    sect_res_o.c     = desc_i[3];
    sect_res_o.b     = desc_i[2];
    sect_res_o.kind  = KIND_SECTION;
  end
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode import ptw_pkg::*; (
  input  logic [AW-1:0] desc_i,
  input  logic [AW-1:0] va_i,
  output xlat_res_t     res_o
);
  logic [AP_W-1:0] sub_ap [NSUB];
  logic unused_va;
  assign unused_va = ^va_i[AW-1:16];

  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    assign sub_ap[g] = desc_i[4 + AP_W*g +: AP_W];
  end

  always_comb begin
    res_o   = '0;
    res_o.c = desc_i[3];
    res_o.b = desc_i[2];
    unique case (desc_i[1:0])
      2'b01: begin
        res_o.kind = KIND_LARGE;
        res_o.pa   = {desc_i[31:16], va_i[15:0]};
        res_o.ap   = sub_ap[va_i[15:14]];
      end
      2'b10: begin
        res_o.kind = KIND_SMALL;
        res_o.pa   = {desc_i[31:12], va_i[11:0]};
        res_o.ap   = sub_ap[va_i[11:10]];
      end
      2'b11: begin
        res_o.kind = KIND_TINY;
        res_o.pa   = {desc_i[31:10], va_i[9:0]};
        res_o.ap   = sub_ap[0];
      end
      default: res_o = fault_res();
    endcase
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker import ptw_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    ttb_i,
  input  logic             req_valid_i,
  input  logic [AW-1:0]    req_va_i,
  output logic             req_ready_o,
  output logic             mem_rd_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [AW-1:0]    mem_rdata_i,
  output logic             done_o,
  output logic             fault_o,
  output logic             fault_level_o,
  output logic [AW-1:0]    pa_o,
  output logic [AP_W-1:0]  ap_o,
  output logic [DOM_W-1:0] domain_o,
  output logic             cacheable_o,
  output logic             bufferable_o,
  output logic [1:0]       kind_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_L1, ST_L2} st_e;

  st_e              state_q;
  logic [AW-1:0]    va_q, addr_q;
  logic [DOM_W-1:0] dom_q;
  xlat_res_t        res_q;
  logic             flvl_q, done_q;

  logic             l1_fault, l1_section;
  logic [DOM_W-1:0] l1_dom;
  logic [AW-1:0]    l1_next;
  xlat_res_t        l1_res, l2_res;

  logic accept, l1_take, l2_take;
  logic unused_ttb;
  assign unused_ttb = ^ttb_i[13:0];

  assign accept  = (state_q == ST_IDLE) && req_valid_i;
  assign l1_take = (state_q == ST_L1) && mem_rvalid_i;
  assign l2_take = (state_q == ST_L2) && mem_rvalid_i;

  ptw_l1_decode u_l1 (
    .desc_i(mem_rdata_i), .va_i(va_q), .fault_o(l1_fault),
    .section_o(l1_section), .domain_o(l1_dom),
    .next_addr_o(l1_next), .sect_res_o(l1_res)
  );

  ptw_l2_decode u_l2 (.desc_i(mem_rdata_i), .va_i(va_q), .res_o(l2_res));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      dom_q   <= '0;
      res_q   <= '0;
      flvl_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          va_q    <= req_va_i;
          addr_q  <= l1_desc_addr(ttb_i, req_va_i);
          state_q <= ST_L1;
        end
        ST_L1: if (l1_take) begin
          dom_q <= l1_dom;
          if (l1_fault || l1_section) begin
            res_q   <= l1_fault ? fault_res() : l1_res;
            flvl_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            addr_q  <= l1_next;
            state_q <= ST_L2;
          end
        end
        ST_L2: if (l2_take) begin
          res_q   <= l2_res;
          flvl_q  <= 1'b1;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign mem_rd_o      = (state_q == ST_L1) || (state_q == ST_L2);
  assign mem_addr_o    = addr_q;
  assign done_o        = done_q;
  assign fault_o       = res_q.fault;
  assign fault_level_o = flvl_q;
  assign pa_o          = res_q.pa;
  assign ap_o          = res_q.ap;
  assign domain_o      = dom_q;
  assign cacheable_o   = res_q.c;
  assign bufferable_o  = res_q.b;
  assign kind_o        = res_q.kind;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o && !mem_rvalid_i |=> mem_rd_o && $stable(mem_addr_o)); // R1
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(l1_take || l2_take)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> !mem_rd_o); // R10
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && fault_o |-> pa_o == '0 && ap_o == '0 && kind_o == '0
                          && !cacheable_o && !bufferable_o); // R6
  AST_L2_FROM_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_L2) |-> $past(l1_take && !l1_fault && !l1_section)); // R4
endmodule

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ttb_i, req_va_i, mem_rdata_i;
  logic        req_valid_i, mem_rvalid_i;
  logic        req_ready_o, mem_rd_o, done_o, fault_o, fault_level_o;
  logic        cacheable_o, bufferable_o;
  logic [31:0] mem_addr_o, pa_o;
  logic [1:0]  ap_o, kind_o;
  logic [3:0]  domain_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ptw_walker dut_i (
    .clk(clk), .rst_n(rst_n), .ttb_i(ttb_i), .req_valid_i(req_valid_i),
    .req_va_i(req_va_i), .req_ready_o(req_ready_o), .mem_rd_o(mem_rd_o),
    .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .done_o(done_o), .fault_o(fault_o),
    .fault_level_o(fault_level_o), .pa_o(pa_o), .ap_o(ap_o),
    .domain_o(domain_o), .cacheable_o(cacheable_o),
    .bufferable_o(bufferable_o), .kind_o(kind_o)
  );

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic serve(string tag, logic [31:0] exp_addr, logic [31:0] data,
                       int lat, bit poke, logic [31:0] va);
    int w = 0;
    while (!mem_rd_o && w < 8) begin
      @(negedge clk);
      w++;
    end
    check_eq({tag, " read addr"}, mem_addr_o, exp_addr);
    for (int i = 0; i < lat; i++) begin
      if (poke) begin
        req_valid_i = 1'b1;
        req_va_i    = ~va;
      end
      @(negedge clk);
      check_eq("R1 strobe held", {31'b0, mem_rd_o}, 32'd1);
      check_eq("R1 addr held", mem_addr_o, exp_addr);
      check_eq("R10 busy not ready", {31'b0, req_ready_o}, 32'd0);
    end
    req_valid_i  = 1'b0;
    mem_rvalid_i = 1'b1;
    mem_rdata_i  = data;
    @(negedge clk);
    mem_rvalid_i = 1'b0;
    mem_rdata_i  = 32'h0;
  endtask

  task automatic walk(logic [31:0] va, logic [31:0] ttb, logic [31:0] d1,
                      logic [31:0] d2, int lat);
    logic [31:0] e_pa;
    logic [1:0]  e_ap, e_kind;
    logic        e_c, e_b, e_fault, e_lvl;
    string       tg;
    int          t1 = int'(d1 & 3);
    int          t2 = int'(d2 & 3);
    e_pa = 0; e_ap = 0; e_kind = 0; e_c = 0; e_b = 0; e_fault = 0; e_lvl = 0;
    ttb_i = ttb;
    check_eq("R10 ready before request", {31'b0, req_ready_o}, 32'd1);
    req_valid_i = 1'b1;
    req_va_i    = va;
    @(negedge clk);
    req_valid_i = 1'b0;
    serve("R1", (ttb & 32'hFFFF_C000) | ((va >> 18) & 32'h3FFC), d1, lat, 1'b1, va);
    if (t1 == 0) begin
      tg = "R2"; e_fault = 1;
    end else if (t1 == 2) begin
      tg = "R3";
      e_pa = (d1 & 32'hFFF0_0000) | (va & 32'h000F_FFFF);
      e_ap = 2'((d1 >> 10) & 3);
      e_c = d1[3]; e_b = d1[2];
    end else begin
      if (t1 == 3)
        serve("R5", (d1 & 32'hFFFF_F000) | ((va >> 8) & 32'hFFC), d2, lat, 1'b0, va);
      else
        serve("R4", (d1 & 32'hFFFF_FC00) | ((va >> 10) & 32'h3FC), d2, lat, 1'b0, va);
      e_lvl = 1;
      e_c = d2[3]; e_b = d2[2]; e_kind = 2'(t2);
      case (t2)
        0: begin tg = "R6"; e_fault = 1; e_c = 0; e_b = 0; end
        1: begin
          tg = "R7";
          e_pa = (d2 & 32'hFFFF_0000) | (va & 32'hFFFF);
          e_ap = 2'((d2 >> (4 + 2 * ((va >> 14) & 3))) & 3);
        end
        2: begin
          tg = "R8";
          e_pa = (d2 & 32'hFFFF_F000) | (va & 32'hFFF);
          e_ap = 2'((d2 >> (4 + 2 * ((va >> 10) & 3))) & 3);
        end
        default: begin
          tg = "R9";
          e_pa = (d2 & 32'hFFFF_FC00) | (va & 32'h3FF);
          e_ap = 2'((d2 >> 4) & 3);
        end
      endcase
    end
    check_eq("R10 done after last data", {31'b0, done_o}, 32'd1);
    check_eq("R2 no further read", {31'b0, mem_rd_o}, 32'd0);
    check_eq({tg, " fault"}, {31'b0, fault_o}, {31'b0, e_fault});
    check_eq({tg, " fault level"}, {31'b0, fault_level_o}, {31'b0, e_lvl});
    check_eq({tg, " pa"}, pa_o, e_pa);
    check_eq({tg, " ap"}, {30'b0, ap_o}, {30'b0, e_ap});
    check_eq({tg, " domain"}, {28'b0, domain_o}, (d1 >> 5) & 32'hF);
    check_eq({tg, " C"}, {31'b0, cacheable_o}, {31'b0, e_c});
    check_eq({tg, " B"}, {31'b0, bufferable_o}, {31'b0, e_b});
    check_eq({tg, " kind"}, {30'b0, kind_o}, {30'b0, e_kind});
    @(negedge clk);
    check_eq("R10 done single pulse", {31'b0, done_o}, 32'd0);
    check_eq("R10 busy request ignored", {31'b0, mem_rd_o}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ttb_i = 0; req_valid_i = 0; req_va_i = 0;
    mem_rvalid_i = 0; mem_rdata_i = 0;
    repeat (3) @(negedge clk);
    check_eq("R11 reset done", {31'b0, done_o}, 32'd0);
    check_eq("R11 reset read", {31'b0, mem_rd_o}, 32'd0);
    check_eq("R11 reset ready", {31'b0, req_ready_o}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int t1 = 0; t1 < 4; t1++) begin
      for (int k = 0; k < 4; k++) begin
        for (int t2 = 0; t2 < 4; t2++) begin
          logic [31:0] va, ttb, d1, d2;
          if ((t1 == 0 || t1 == 2) && t2 != 0) continue;
          va  = ((32'h7B53_3123 * (t1 + 2 * k + 3 * t2 + 1)) & ~32'h0000_CC00)
                | (32'(k) << 14) | (32'(k) << 10);
          ttb = (k[0]) ? 32'h1234_7FFF : 32'hABCD_C000;
          d1  = ((32'hC3A5_5F6C ^ (32'(k) * 32'h0101_0120)) & ~32'h3) | 32'(t1);
          d2  = ((32'h5E7D_B9E4 ^ (32'(t2) * 32'h1003_0008)) & ~32'h3) | 32'(t2);
          walk(va, ttb, d1, d2, (k + t2) % 3);
        end
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule